// File: doc/BRIEF.md
# External Memory Width Adapter

This block joins a 32-bit processor load/store port to an external memory bus whose physical width is 8, 16 or 32 bits. A request moves a byte, a halfword or a word. When the request is wider than the memory, the block issues several consecutive bus cycles, lowest part first, and gathers the read parts into one 32-bit value. When the request fits in the memory width, it issues a single bus cycle on the byte lanes picked by the low address bits. Narrow reads are returned in the low bits of a 32-bit result, with the upper bits zero-filled or sign-extended.

A strap pin sampled during reset picks the default physical width: a low level selects 32 bits and a high level selects 16 bits. A control write port can later change the width and the extension mode. Such a write never disturbs an access in flight: it is held and applied once the access has ended. The live strap level is mirrored on a status output. A blackout flag marks the cycle before and the cycle after each change of that status, so that instruction fetches can be kept off the external bus while the width strap is moving.

Top module: `mem_width_adapter`

## Requirements
- R1: While rstN is low, cfgWidthQ is set to 1 (16-bit) if strapPin is high and to 2 (32-bit) if it is low, cfgSignExtQ is set to 1, and busValid and doneValid are low; strapPin changes outside reset leave cfgWidthQ unchanged.
- R2: strapStatus equals the level strapPin had at the previous rising clock edge.
- R3: fetchBlackout is high in every cycle where strapPin differs from strapStatus, and in the cycle right after strapStatus has changed; otherwise it is low.
- R4: With memory width code w and size code s, a request takes 2^(s-w) bus cycles when s > w and exactly one bus cycle otherwise.
- R5: In a multi-cycle access, cycle k uses address (reqAddr rounded down to the size) + k * (memory bytes), carries data bytes k*mb .. k*mb+mb-1 on lanes 0..mb-1 (lane j is busWdata[8j+7:8j], enabled by busByteEn[j]), and enables only those mb lanes.
- R6: In a single-cycle access, busAddr is reqAddr rounded down to the memory width, the lane offset is the address offset within the memory word rounded down to the size, and only the size's bytes at that offset are enabled; address bits below the size are ignored.
- R7: Read data is assembled little-endian: the byte at the lowest address lands in bits 7:0 of doneRdata.
- R8: For byte and halfword reads, the bits above the data are copies of its top bit when the extension mode is 1 and zeros when it is 0.
- R9: A request is taken when reqValid is high while the block is idle and must be held until doneValid; doneValid is high for exactly one cycle, the cycle after the final bus cycle completes, and busValid is low in that cycle.
- R10: A control write while bus cycles are in progress does not change cfgWidthQ, cfgSignExtQ or the running access; it takes effect once the access has finished. A write while idle takes effect at the next edge.
- R11: Width codes are 0 = 8-bit, 1 = 16-bit, 2 = 32-bit, and code 3 is stored as 2; size codes are 0 = byte, 1 = halfword, 2 = word, and code 3 acts as word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| strapPin | input | 1 | Width strap (high = 16-bit default, low = 32-bit default) |
| reqValid | input | 1 | Request present; held until doneValid |
| reqWrite | input | 1 | 1 = store, 0 = load |
| reqSize | input | 2 | Data size code |
| reqAddr | input | ADDR_W | Byte address |
| reqWdata | input | 32 | Store data, right-aligned |
| doneValid | output | 1 | One-cycle completion pulse |
| doneRdata | output | 32 | Assembled and extended load data |
| cfgWrite | input | 1 | Control register write strobe |
| cfgWidth | input | 2 | New physical width code |
| cfgSignExt | input | 1 | New extension mode (1 = sign, 0 = zero) |
| cfgWidthQ | output | 2 | Active physical width code |
| cfgSignExtQ | output | 1 | Active extension mode |
| strapStatus | output | 1 | Registered strap level |
| fetchBlackout | output | 1 | No instruction fetch allowed this cycle |
| busValid | output | 1 | Bus cycle in progress |
| busReady | input | 1 | Bus cycle completes at this edge |
| busWrite | output | 1 | Bus cycle direction |
| busAddr | output | ADDR_W | Byte address of the bus cycle |
| busByteEn | output | 4 | Active byte lanes |
| busWdata | output | 32 | Write data on lanes |
| busRdata | input | 32 | Read data on lanes |

## Verification
The bench builds the adapter with a 16-bit address, which keeps its byte-wide memory model small while letting the rounding and per-cycle address steps run through their carries. All three memory widths are reached at run time through the control port, so every pairing of size and width, including the four-cycle byte-memory word access, is exercised against the same model. The model drives filler bytes onto lanes above the physical width, so any read that picks up an unused lane shows up in the result; writes are checked against the neighbouring bytes as well as the target ones.

// File: rtl/mwa_pkg.sv
package mwa_pkg;

  localparam int DATA_W     = 32;
  localparam int LANES      = DATA_W / 8;
  localparam int LANE_IDX_W = $clog2(LANES);
  localparam int BEAT_CNT_W = LANE_IDX_W + 1;

  localparam logic [1:0] WIDTH_8  = 2'd0;
  localparam logic [1:0] WIDTH_16 = 2'd1;
  localparam logic [1:0] WIDTH_32 = 2'd2;

  typedef enum logic [1:0] {
    XF_IDLE = 2'd0,
    XF_BUSY = 2'd1,
    XF_DONE = 2'd2
  } xferState_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic start;     // request accepted this cycle
    logic active;    // a bus cycle is being presented
    logic beatDone;  // current bus cycle completes at this edge
  } dpStrobe_t;

  // Size and width codes: 3 folds onto the 32-bit code.
  function automatic logic [1:0] normLog(input logic [1:0] code);
    return (code == 2'd3) ? 2'd2 : code;
  endfunction

  function automatic logic [LANES-1:0] laneMaskOf(input logic [1:0] log2Bytes);
    logic [LANES-1:0] m;
    for (int i = 0; i < LANES; i++) m[i] = (i < (1 << log2Bytes));
    return m;
  endfunction

  function automatic logic [DATA_W-1:0] laneBits(input logic [LANES-1:0] m);
    logic [DATA_W-1:0] b;
    for (int i = 0; i < LANES; i++) b[i*8 +: 8] = {8{m[i]}};
    return b;
  endfunction

endpackage

// File: rtl/mwa_ctrl.sv
module mwa_ctrl
  import mwa_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  strapPin,
  input  logic                  reqValid,
  input  logic [1:0]            reqSize,
  input  logic                  busReady,
  input  logic                  cfgWrite,
  input  logic [1:0]            cfgWidth,
  input  logic                  cfgSignExt,
  output logic                  busValid,
  output logic                  doneValid,
  output dpStrobe_t             strobe,
  output logic [1:0]            xferWidth,
  output logic [1:0]            xferSize,
  output logic                  xferSignExt,
  output logic [LANE_IDX_W-1:0] beatIdx,
  output logic [1:0]            cfgWidthQ,
  output logic                  cfgSignExtQ,
  output logic                  strapStatus,
  output logic                  fetchBlackout
);

  xferState_t            state;
  logic [1:0]            pendWidth;
  logic                  pendSignExt;
  logic                  pendValid;
  logic                  strapQ1;
  logic                  strapQ2;
  logic [BEAT_CNT_W-1:0] beatsNeeded;
  logic                  lastBeat;
  logic                  handshake;

  always_comb begin
    if (xferSize > xferWidth) beatsNeeded = BEAT_CNT_W'(1) << (xferSize - xferWidth);
    else                      beatsNeeded = BEAT_CNT_W'(1);
  end

  assign lastBeat  = ({1'b0, beatIdx} == (beatsNeeded - BEAT_CNT_W'(1)));
  assign handshake = (state == XF_BUSY) && busReady;

  assign busValid        = (state == XF_BUSY);
  assign doneValid       = (state == XF_DONE);
  assign strobe.start    = (state == XF_IDLE) && reqValid;
  assign strobe.active   = (state == XF_BUSY);
  assign strobe.beatDone = handshake;

  assign strapStatus   = strapQ1;
  assign fetchBlackout = (strapPin != strapQ1) || (strapQ1 != strapQ2);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= XF_IDLE;
      beatIdx     <= '0;
      xferWidth   <= WIDTH_32;
      xferSize    <= 2'd0;
      xferSignExt <= 1'b0;
      cfgWidthQ   <= strapPin ? WIDTH_16 : WIDTH_32;
      cfgSignExtQ <= 1'b1;
      pendValid   <= 1'b0;
      pendWidth   <= WIDTH_32;
      pendSignExt <= 1'b1;
      strapQ1     <= strapPin;
      strapQ2     <= strapPin;
    end else begin
      strapQ1 <= strapPin;
      strapQ2 <= strapQ1;

      case (state)
        XF_IDLE: begin
          if (reqValid) begin
            state       <= XF_BUSY;
            beatIdx     <= '0;
            xferWidth   <= cfgWidthQ;
            xferSize    <= normLog(reqSize);
            xferSignExt <= cfgSignExtQ;
          end
        end
        XF_BUSY: begin
          if (handshake) begin
            if (lastBeat) state <= XF_DONE;
            else          beatIdx <= beatIdx + LANE_IDX_W'(1);
          end
        end
        XF_DONE: state <= XF_IDLE;
        default: state <= XF_IDLE;
      endcase

      // Control writes land only outside of bus activity.
      if (state == XF_BUSY) begin
        if (cfgWrite) begin
          pendValid   <= 1'b1;
          pendWidth   <= normLog(cfgWidth);
          pendSignExt <= cfgSignExt;
        end
      end else begin
        pendValid <= 1'b0;
        if (cfgWrite) begin
          cfgWidthQ   <= normLog(cfgWidth);
          cfgSignExtQ <= cfgSignExt;
        end else if (pendValid) begin
          cfgWidthQ   <= pendWidth;
          cfgSignExtQ <= pendSignExt;
        end
      end
    end
  end

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);

  // R9
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busReady && lastBeat) |=> (doneValid && !busValid));

  // R4
  beat_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    busValid |-> ({1'b0, beatIdx} < beatsNeeded));

  // R10
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && $past(busValid)) |-> ($stable(cfgWidthQ) && $stable(cfgSignExtQ)));

  // R3
  blackout_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strapStatus != $past(strapStatus)) |-> fetchBlackout);

endmodule

// File: rtl/mwa_datapath.sv
module mwa_datapath
  import mwa_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  dpStrobe_t             strobe,
  input  logic [1:0]            xferWidth,
  input  logic [1:0]            xferSize,
  input  logic                  xferSignExt,
  input  logic [LANE_IDX_W-1:0] beatIdx,
  input  logic                  reqWrite,
  input  logic [ADDR_W-1:0]     reqAddr,
  input  logic [DATA_W-1:0]     reqWdata,
  input  logic [DATA_W-1:0]     busRdata,
  output logic [ADDR_W-1:0]     busAddr,
  output logic                  busWrite,
  output logic [LANES-1:0]      busByteEn,
  output logic [DATA_W-1:0]     busWdata,
  output logic [DATA_W-1:0]     doneRdata
);

  logic [ADDR_W-1:0]     addrQ;
  logic                  writeQ;
  logic [DATA_W-1:0]     wdataQ;
  logic [DATA_W-1:0]     acc;
  logic [DATA_W-1:0]     accNext;

  logic                  multiBeat;
  logic [ADDR_W-1:0]     widthMask;
  logic [ADDR_W-1:0]     sizeMask;
  logic [LANES-1:0]      widthLanes;
  logic [LANES-1:0]      sizeLanes;
  logic [LANE_IDX_W-1:0] partOff;
  logic [LANE_IDX_W-1:0] laneOff;

  assign multiBeat  = (xferSize > xferWidth);
  assign widthMask  = ADDR_W'((32'd1 << xferWidth) - 32'd1);
  assign sizeMask   = ADDR_W'((32'd1 << xferSize) - 32'd1);
  assign widthLanes = laneMaskOf(xferWidth);
  assign sizeLanes  = laneMaskOf(xferSize);
  assign partOff    = LANE_IDX_W'(int'(beatIdx) << xferWidth);
  assign laneOff    = addrQ[LANE_IDX_W-1:0] & widthMask[LANE_IDX_W-1:0]
                    & ~sizeMask[LANE_IDX_W-1:0];
  assign busWrite   = writeQ;

  // Bus-side address, lanes and write data for the current cycle.
  always_comb begin
    if (multiBeat) begin
      busAddr   = (addrQ & ~sizeMask) + ADDR_W'(partOff);
      busByteEn = widthLanes;
      busWdata  = (wdataQ >> (int'(partOff) * 8)) & laneBits(widthLanes);
    end else begin
      busAddr   = addrQ & ~widthMask;
      busByteEn = sizeLanes << laneOff;
      busWdata  = (wdataQ & laneBits(sizeLanes)) << (int'(laneOff) * 8);
    end
  end

  // Read merge: wide parts are stacked, a single part is shifted down.
  always_comb begin
    accNext = acc;
    if (multiBeat) begin
      for (int j = 0; j < LANES; j++) begin
        if (widthLanes[j] && ((int'(partOff) + j) < LANES))
          accNext[(int'(partOff) + j) * 8 +: 8] = busRdata[j*8 +: 8];
      end
    end else begin
      accNext = busRdata >> (int'(laneOff) * 8);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      writeQ <= 1'b0;
      wdataQ <= '0;
      acc    <= '0;
    end else if (strobe.start) begin
      addrQ  <= reqAddr;
      writeQ <= reqWrite;
      wdataQ <= reqWdata;
      acc    <= '0;
    end else if (strobe.beatDone && !writeQ) begin
      acc <= accNext;
    end
  end

  always_comb begin
    case (xferSize)
      2'd0:    doneRdata = {{(DATA_W-8){xferSignExt & acc[7]}}, acc[7:0]};
      2'd1:    doneRdata = {{(DATA_W-16){xferSignExt & acc[15]}}, acc[15:0]};
      default: doneRdata = acc;
    endcase
  end

  // R6
  single_lane_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.active && xferSize == 2'd0) |-> ($countones(busByteEn) == 1));

  // R5
  addr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.active && $past(strobe.active) && $past(strobe.beatDone))
      |-> (busAddr == $past(busAddr) + ADDR_W'(32'd1 << xferWidth)));

endmodule

// File: rtl/mem_width_adapter.sv
module mem_width_adapter
  import mwa_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              strapPin,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [1:0]        reqSize,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [31:0]       reqWdata,
  output logic              doneValid,
  output logic [31:0]       doneRdata,
  input  logic              cfgWrite,
  input  logic [1:0]        cfgWidth,
  input  logic              cfgSignExt,
  output logic [1:0]        cfgWidthQ,
  output logic              cfgSignExtQ,
  output logic              strapStatus,
  output logic              fetchBlackout,
  output logic              busValid,
  input  logic              busReady,
  output logic              busWrite,
  output logic [ADDR_W-1:0] busAddr,
  output logic [3:0]        busByteEn,
  output logic [31:0]       busWdata,
  input  logic [31:0]       busRdata
);

  dpStrobe_t             strobe;
  logic [1:0]            xferWidth;
  logic [1:0]            xferSize;
  logic                  xferSignExt;
  logic [LANE_IDX_W-1:0] beatIdx;

  mwa_ctrl u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .strapPin      (strapPin),
    .reqValid      (reqValid),
    .reqSize       (reqSize),
    .busReady      (busReady),
    .cfgWrite      (cfgWrite),
    .cfgWidth      (cfgWidth),
    .cfgSignExt    (cfgSignExt),
    .busValid      (busValid),
    .doneValid     (doneValid),
    .strobe        (strobe),
    .xferWidth     (xferWidth),
    .xferSize      (xferSize),
    .xferSignExt   (xferSignExt),
    .beatIdx       (beatIdx),
    .cfgWidthQ     (cfgWidthQ),
    .cfgSignExtQ   (cfgSignExtQ),
    .strapStatus   (strapStatus),
    .fetchBlackout (fetchBlackout)
  );

  mwa_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .xferWidth   (xferWidth),
    .xferSize    (xferSize),
    .xferSignExt (xferSignExt),
    .beatIdx     (beatIdx),
    .reqWrite    (reqWrite),
    .reqAddr     (reqAddr),
    .reqWdata    (reqWdata),
    .busRdata    (busRdata),
    .busAddr     (busAddr),
    .busWrite    (busWrite),
    .busByteEn   (busByteEn),
    .busWdata    (busWdata),
    .doneRdata   (doneRdata)
  );

endmodule

// File: tb/tb_mem_width_adapter.sv
module tb_mem_width_adapter;

  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          strapPin = 1'b1;
  logic          reqValid = 1'b0;
  logic          reqWrite = 1'b0;
  logic [1:0]    reqSize = 2'd0;
  logic [AW-1:0] reqAddr = '0;
  logic [31:0]   reqWdata = '0;
  logic          doneValid;
  logic [31:0]   doneRdata;
  logic          cfgWrite = 1'b0;
  logic [1:0]    cfgWidth = 2'd0;
  logic          cfgSignExt = 1'b0;
  logic [1:0]    cfgWidthQ;
  logic          cfgSignExtQ;
  logic          strapStatus;
  logic          fetchBlackout;
  logic          busValid;
  logic          busReady = 1'b1;
  logic          busWrite;
  logic [AW-1:0] busAddr;
  logic [3:0]    busByteEn;
  logic [31:0]   busWdata;
  logic [31:0]   busRdata;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int physLog = 2;
  bit monOn = 1'b0;
  logic e0, e1;
  logic [7:0] mem  [0:255];
  logic [7:0] snap [0:255];
  int addrLog[$];

  always #5 clk = ~clk;

  mem_width_adapter #(.ADDR_W(AW)) dut (
    .clk(clk), .rstN(rstN), .strapPin(strapPin),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqSize(reqSize),
    .reqAddr(reqAddr), .reqWdata(reqWdata),
    .doneValid(doneValid), .doneRdata(doneRdata),
    .cfgWrite(cfgWrite), .cfgWidth(cfgWidth), .cfgSignExt(cfgSignExt),
    .cfgWidthQ(cfgWidthQ), .cfgSignExtQ(cfgSignExtQ),
    .strapStatus(strapStatus), .fetchBlackout(fetchBlackout),
    .busValid(busValid), .busReady(busReady), .busWrite(busWrite),
    .busAddr(busAddr), .busByteEn(busByteEn), .busWdata(busWdata),
    .busRdata(busRdata)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Memory model: lanes above the physical width carry filler.
  always_comb begin
    for (int j = 0; j < 4; j++)
      busRdata[j*8 +: 8] = (j < (1 << physLog)) ? mem[(int'(busAddr) + j) & 255] : 8'hA5;
  end

  always @(posedge clk) begin
    if (rstN && busValid && busReady) begin
      addrLog.push_back(int'(busAddr));
      if (busWrite)
        for (int j = 0; j < 4; j++)
          if (busByteEn[j]) mem[(int'(busAddr) + j) & 255] <= busWdata[j*8 +: 8];
    end
  end

  always @(negedge clk) begin
    cyc++;
    busReady = ((cyc % 3) != 2);
  end

  // Strap history and per-clock comparison of status and blackout.
  always @(posedge clk) begin
    e1 <= e0;
    e0 <= strapPin;
  end

  always @(negedge clk) begin
    #2;
    if (rstN && monOn) begin
      chk("R2", "strap status", 32'(strapStatus), 32'(e0));
      chk("R3", "blackout", 32'(fetchBlackout), 32'((strapPin !== e0) || (e0 !== e1)));
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual running expected finished");
    finishRun();
  end

  function automatic logic [31:0] expRead(input int sz, input int addr, input bit sgn);
    int a = addr & ~((1 << sz) - 1);
    logic [31:0] v = '0;
    for (int i = 0; i < (1 << sz); i++) v[i*8 +: 8] = mem[(a + i) & 255];
    if (sz == 0) v = {{24{sgn & v[7]}}, v[7:0]};
    if (sz == 1) v = {{16{sgn & v[15]}}, v[15:0]};
    return v;
  endfunction

  task automatic doReset(input logic pin);
    @(negedge clk);
    rstN = 1'b0;
    strapPin = pin;
    reqValid = 1'b0;
    cfgWrite = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    monOn = 1'b1;
    // R1
    chk("R1", "reset width", 32'(cfgWidthQ), pin ? 32'd1 : 32'd2);
    chk("R1", "reset ext", 32'(cfgSignExtQ), 32'd1);
    chk("R1", "reset busValid", 32'(busValid), 32'd0);
    chk("R1", "reset doneValid", 32'(doneValid), 32'd0);
  endtask

  task automatic cfgSet(input logic [1:0] w, input logic s);
    @(negedge clk);
    cfgWrite = 1'b1;
    cfgWidth = w;
    cfgSignExt = s;
    @(negedge clk);
    cfgWrite = 1'b0;
    chk((w == 2'd3) ? "R11" : "R10", "idle cfg width", 32'(cfgWidthQ),
        (w == 2'd3) ? 32'd2 : 32'(w));
    chk("R10", "idle cfg ext", 32'(cfgSignExtQ), 32'(s));
  endtask

  task automatic xfer(input bit wr, input logic [1:0] size, input int addr,
                      input logic [31:0] wd, output logic [31:0] rd);
    int n = 0;
    @(negedge clk);
    addrLog.delete();
    reqWrite = wr;
    reqSize = size;
    reqAddr = AW'(addr);
    reqWdata = wd;
    reqValid = 1'b1;
    do begin
      @(negedge clk);
      n++;
    end while (!doneValid && n < 60);
    if (!doneValid) chk("R9", "done seen", 32'd0, 32'd1);
    chk("R9", "bus idle at done", 32'(busValid), 32'd0);
    rd = doneRdata;
    reqValid = 1'b0;
    @(negedge clk);
    chk("R9", "done one cycle", 32'(doneValid), 32'd0);
  endtask

  task automatic checkAddrs(input int sz, input int addr);
    int mb = 1 << physLog;
    int beats = (sz > physLog) ? (1 << (sz - physLog)) : 1;
    chk("R4", "bus cycle count", 32'(addrLog.size()), 32'(beats));
    for (int k = 0; k < addrLog.size(); k++) begin
      if (sz > physLog)
        chk("R5", "part address", 32'(addrLog[k]), 32'((addr & ~((1 << sz) - 1)) + k * mb));
      else
        chk("R6", "single address", 32'(addrLog[k]), 32'(addr & ~(mb - 1)));
    end
  endtask

  task automatic runRead(input logic [1:0] size, input int addr, input bit sgn);
    int sz = (size == 2'd3) ? 2 : int'(size);
    logic [31:0] exp = expRead(sz, addr, sgn);
    logic [31:0] got;
    xfer(1'b0, size, addr, 32'h0, got);
    chk((sz == 2) ? "R7" : "R8", "read data", got, exp);
    checkAddrs(sz, addr);
  endtask

  task automatic runWrite(input logic [1:0] size, input int addr, input logic [31:0] wd);
    int sz = int'(size);
    int a = addr & ~((1 << sz) - 1);
    logic [31:0] dummy;
    int lo = (addr & ~3) - 4;
    for (int i = 0; i < 256; i++) snap[i] = mem[i];
    xfer(1'b1, size, addr, wd, dummy);
    checkAddrs(sz, addr);
    for (int i = lo; i < lo + 12; i++) begin
      if (i >= a && i < a + (1 << sz))
        chk((sz > physLog) ? "R5" : "R6", "written byte", 32'(mem[i & 255]), 32'(wd[(i - a)*8 +: 8]));
      else
        chk((sz > physLog) ? "R5" : "R6", "neighbour byte", 32'(mem[i & 255]), 32'(snap[i & 255]));
    end
  endtask

  initial begin
    logic [31:0] got;
    int n;
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 37 + 11);

    doReset(1'b1);

    // Every width, size and offset; sign then zero extension.
    for (int w = 0; w < 3; w++) begin
      physLog = w;
      cfgSet(2'(w), 1'b1);
      for (int s = 0; s < 3; s++) begin
        for (int off = 0; off < 4; off++) begin
          runWrite(2'(s), 64 + w * 48 + s * 12 + off,
                   32'hF0E1D2C3 + off * 32'h01010101 + s);
          runRead(2'(s), 64 + w * 48 + s * 12 + off, 1'b1);
          runRead(2'(s), 16 + off * 4 + s, 1'b1);
        end
      end
      cfgSet(2'(w), 1'b0);
      for (int s = 0; s < 2; s++)
        for (int off = 0; off < 4; off++)
          runRead(2'(s), 32 + off + s * 8, 1'b0);
    end

    // R10: control write during a four-cycle access is deferred.
    physLog = 0;
    cfgSet(2'd0, 1'b1);
    @(negedge clk);
    addrLog.delete();
    reqWrite = 1'b0;
    reqSize = 2'd2;
    reqAddr = AW'(200);
    reqValid = 1'b1;
    @(negedge clk);
    @(negedge clk);
    cfgWrite = 1'b1;
    cfgWidth = 2'd2;
    cfgSignExt = 1'b0;
    @(negedge clk);
    cfgWrite = 1'b0;
    chk("R10", "width held while busy", 32'(cfgWidthQ), 32'd0);
    chk("R10", "ext held while busy", 32'(cfgSignExtQ), 32'd1);
    n = 0;
    while (!doneValid && n < 60) begin
      @(negedge clk);
      n++;
    end
    chk("R10", "old width used", 32'(addrLog.size()), 32'd4);
    chk("R10", "read under old width", doneRdata, expRead(2, 200, 1'b1));
    chk("R10", "width at done", 32'(cfgWidthQ), 32'd0);
    reqValid = 1'b0;
    @(negedge clk);
    chk("R10", "width applied after", 32'(cfgWidthQ), 32'd2);
    chk("R10", "ext applied after", 32'(cfgSignExtQ), 32'd0);

    // R11: width code 3 and size code 3.
    physLog = 2;
    cfgSet(2'd3, 1'b1);
    runRead(2'd3, 101, 1'b1);
    physLog = 0;
    cfgSet(2'd0, 1'b1);
    runRead(2'd3, 150, 1'b1);

    // R3 / R1: strap movement outside reset.
    physLog = 1;
    cfgSet(2'd1, 1'b1);
    @(negedge clk);
    strapPin = 1'b0;
    #1 chk("R3", "blackout before status change", 32'(fetchBlackout), 32'd1);
    @(negedge clk);
    #1 chk("R3", "blackout after status change", 32'(fetchBlackout), 32'd1);
    @(negedge clk);
    #1 chk("R3", "blackout cleared", 32'(fetchBlackout), 32'd0);
    chk("R1", "strap ignored outside reset", 32'(cfgWidthQ), 32'd1);
    repeat (2) @(negedge clk);
    strapPin = 1'b1;
    @(negedge clk);
    strapPin = 1'b0;
    repeat (4) @(negedge clk);
    runRead(2'd2, 40, 1'b1);

    doReset(1'b0);
    physLog = 2;
    runRead(2'd1, 90, 1'b1);
    runRead(2'd0, 91, 1'b1);

    repeat (3) @(negedge clk);
    finishRun();
  end

endmodule